// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block produces the integer divide ratio that a fractional-N PLL feedback counter uses, one value per divider output cycle. Over many cycles the ratios average to INT + FRAC/MOD. The clock input stands for the edge that drives the feedback counter. An internal programmable down-counter spends exactly `div_value` clocks on each divider cycle and raises `div_pulse` for one clock at the end of each one. At that boundary a three-stage cascade of first-order accumulators advances once. Each stage wraps modulo MOD, and MOD need not be a power of two. The cascade's combined carry moves the next ratio between INT−3 and INT+4.

New settings are captured by a one-clock `load` strobe and held pending. They take effect at the next divider-cycle boundary. Applying a setting clears the accumulators, and the first divider cycle after it uses INT exactly. An illegal setting raises `cfg_err` and stops the counter. So does a dithered ratio that would leave the supported counter range. While stopped, the next load is applied on the following clock. The outputs are plain level and pulse signals with no handshake. The counter never waits for a consumer, so there is no back-pressure: every `div_pulse` has to be taken when it happens.

Top module: `fracn_ratio_gen`

## Requirements
- R1: Reset loads INT=32, FRAC=0, MOD=2. During and right after reset, `div_value` is 32, `cfg_err` is 0 and `div_pulse` is 0. The first `div_pulse` comes 31 rising edges after the last reset edge.
- R2: In normal operation, the number of clocks from one `div_pulse` to the next equals the `div_value` shown at the second pulse, and each pulse lasts one clock.
- R3: With FRAC=0, every divider cycle after the setting takes effect has `div_value` equal to INT.
- R4: Starting from the first dithered cycle after a setting takes effect, the sum of `div_value` over MOD·k divider cycles differs from k·(MOD·INT+FRAC) by at most 3.
- R5: Without an error, every `div_value` after a setting takes effect lies in INT−3 to INT+4.
- R6: A load that is captured mid-cycle does not change `div_value` before the next `div_pulse`. The cycle after that pulse has `div_value` equal to the new INT exactly.
- R7: A setting with MOD<2, FRAC≥MOD, or INT outside 31..511 raises `cfg_err` once it is applied. While `cfg_err` is 1, `div_pulse` stays 0 and `div_value` holds.
- R8: If INT plus the dither offset would fall outside 31..511, the block raises `cfg_err` after the boundary pulse instead of using that ratio, and `div_value` keeps its last legal value.
- R9: While `cfg_err` is 1, a captured load is applied on the next clock. A legal setting clears `cfg_err` and sets `div_value` to its INT.
- R10: The ratio sequence follows the rule below on every clock.
  - Each stage s adds its input to its accumulator. If the sum is MOD or more, it subtracts MOD and sets carry c_s.
  - Stage 1's input is FRAC. Stages 2 and 3 take the new residue of the stage before them.
  - The offset is c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' marks the value from the previous step and '' the value from the step before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Feedback-side clock that the divider counts |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-clock strobe that captures the three setting inputs |
| int_in | input | 9 | Integer part of the ratio (31..511 legal) |
| frac_in | input | 12 | Fraction numerator (0..MOD−1 legal) |
| mod_in | input | 12 | Fraction modulus (2..4095 legal) |
| div_value | output | 9 | Divide ratio of the divider cycle in progress |
| div_pulse | output | 1 | One-clock pulse at the last clock of each divider cycle |
| cfg_err | output | 1 | Stopped because of an illegal setting or an out-of-range ratio |

## Verification
Several properties are checked on every clock. Each accumulator input stays below the modulus, the dither offset stays in −3..+4, and the active setting changes only at a boundary. While running, the active FRAC stays below MOD and `div_value` stays inside the counter range. A reload never produces a pulse on the next clock. Other behaviour can only be shown by the bench's scenarios. Those are the long-run average over whole multiples of MOD, the exact INT on the first cycle after a change, the stop-and-recover sequence after illegal settings, and the dithered ratio crossing the low edge of the range. A behavioural model then compares the cycle-by-cycle sequence against the design.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int W_INT = 9;
  localparam int W_MOD = 12;

  typedef struct packed {
    logic [W_INT-1:0] n_int;
    logic [W_MOD-1:0] frac;
    logic [W_MOD-1:0] modulus;
  } ratio_cfg_t;
endpackage

// File: rtl/fracn_acc.sv
module fracn_acc #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] modulus,
  output logic         carry,
  output logic [W-1:0] residue
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, addend};
  assign carry   = (sum >= {1'b0, modulus});
  assign residue = carry ? W'(sum - {1'b0, modulus}) : sum[W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (step)  acc_q <= residue;
  end

  // R10: the wrap by one subtraction is exact only for inputs below the modulus
  assert_addend_in_range_R10: assert property (@(posedge clk) disable iff (rst)
    step |-> (addend < modulus));
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash #(
  parameter int W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [W-1:0]      frac,
  input  logic [W-1:0]      modulus,
  output logic signed [3:0] offset
);
  localparam int STAGES = 3;

  logic [W-1:0]      feed [0:STAGES];
  logic [STAGES-1:0] cy;
  logic              c2_d, c3_d, c3_dd;

  assign feed[0] = frac;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    fracn_acc #(.W(W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .step    (step),
      .addend  (feed[g]),
      .modulus (modulus),
      .carry   (cy[g]),
      .residue (feed[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (step) begin
      c2_d  <= cy[1];
      c3_d  <= cy[2];
      c3_dd <= c3_d;
    end
  end

  assign offset = $signed({3'b000, cy[0]})
                + $signed({3'b000, cy[1]}) - $signed({3'b000, c2_d})
                + $signed({3'b000, cy[2]}) - $signed({2'b00, c3_d, 1'b0})
                + $signed({3'b000, c3_dd});

  // R5: combined carry stays inside the dither window
  assert_offset_window_R5: assert property (@(posedge clk) disable iff (rst)
    (offset >= -4'sd3) && (offset <= 4'sd4));
endmodule

// File: rtl/fracn_divcnt.sv
module fracn_divcnt #(
  parameter int W       = 9,
  parameter int RST_VAL = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         reload,
  input  logic [W-1:0] reload_val,
  output logic         tc
);
  logic [W-1:0] cnt_q;

  assign tc = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= W'(RST_VAL - 1);
    else if (reload)        cnt_q <= reload_val - W'(1);
    else if (run && !tc)    cnt_q <= cnt_q - W'(1);
  end

  // R2: a fresh divider cycle never ends on its first clock (ratios are at least 31)
  assert_no_instant_tc_R2: assert property (@(posedge clk) disable iff (rst)
    reload |=> !tc);
endmodule

// File: rtl/fracn_ratio_gen.sv
module fracn_ratio_gen
  import fracn_pkg::*;
#(
  parameter int N_MIN   = 31,
  parameter int N_MAX   = 511,
  parameter int RST_INT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W_INT-1:0] int_in,
  input  logic [W_MOD-1:0] frac_in,
  input  logic [W_MOD-1:0] mod_in,
  output logic [W_INT-1:0] div_value,
  output logic             div_pulse,
  output logic             cfg_err
);
  localparam int W_C = W_INT + 2;
  localparam logic signed [W_C-1:0] C_MIN = W_C'(N_MIN);
  localparam logic signed [W_C-1:0] C_MAX = W_C'(N_MAX);

  ratio_cfg_t        shadow_q, act_q;
  logic              pend_q, err_q;
  logic [W_INT-1:0]  ratio_q;
  logic              tc, tick, apply, step_mod, new_ok, cand_ok, reload;
  logic signed [3:0] offset;
  logic signed [W_C-1:0] cand;
  logic [W_INT-1:0]  reload_val;

  assign tick     = err_q ? pend_q : tc;
  assign apply    = tick && pend_q;
  assign cand     = $signed({2'b00, act_q.n_int}) + {{(W_C-4){offset[3]}}, offset};
  assign cand_ok  = (cand >= C_MIN) && (cand <= C_MAX);
  assign step_mod = tick && !pend_q && cand_ok;
  assign new_ok   = (shadow_q.modulus >= W_MOD'(2))
                 && (shadow_q.frac < shadow_q.modulus)
                 && (shadow_q.n_int >= W_INT'(N_MIN))
                 && (shadow_q.n_int <= W_INT'(N_MAX));
  assign reload     = (apply && new_ok) || step_mod;
  assign reload_val = apply ? shadow_q.n_int : cand[W_INT-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '{n_int: W_INT'(RST_INT), frac: '0, modulus: W_MOD'(2)};
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      ratio_q  <= W_INT'(RST_INT);
    end else begin
      if (apply) begin
        act_q <= shadow_q;
        if (new_ok) begin
          ratio_q <= shadow_q.n_int;
          err_q   <= 1'b0;
        end else begin
          err_q   <= 1'b1;
        end
      end else if (tick) begin
        if (cand_ok) ratio_q <= cand[W_INT-1:0];
        else         err_q   <= 1'b1;
      end
      pend_q <= load || (pend_q && !apply);
      if (load) shadow_q <= '{n_int: int_in, frac: frac_in, modulus: mod_in};
    end
  end

  fracn_mash #(.W(W_MOD)) u_mash (
    .clk     (clk),
    .rst     (rst),
    .clr     (apply),
    .step    (step_mod),
    .frac    (act_q.frac),
    .modulus (act_q.modulus),
    .offset  (offset)
  );

  fracn_divcnt #(.W(W_INT), .RST_VAL(RST_INT)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .run        (!err_q),
    .reload     (reload),
    .reload_val (reload_val),
    .tc         (tc)
  );

  assign div_value = ratio_q;
  assign div_pulse = tc && !err_q;
  assign cfg_err   = err_q;

  // R6: the active setting moves only on a boundary
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(act_q));
  // R7: while running, the active fraction is a proper fraction
  assert_frac_proper_R7: assert property (@(posedge clk) disable iff (rst)
    !err_q |-> (act_q.frac < act_q.modulus));
  // R8: while running, the ratio is one the counter supports
  assert_ratio_range_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_err |-> ((div_value >= W_INT'(N_MIN)) && (div_value <= W_INT'(N_MAX))));
endmodule

// File: tb/fracn_ratio_gen_test.sv
module fracn_ratio_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [8:0]  int_in = '0;
  logic [11:0] frac_in = '0;
  logic [11:0] mod_in = '0;
  logic [8:0]  div_value;
  logic        div_pulse;
  logic        cfg_err;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  fracn_ratio_gen uut (
    .clk(clk), .rst(rst), .load(load), .int_in(int_in), .frac_in(frac_in),
    .mod_in(mod_in), .div_value(div_value), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference of the requirements
  int m_int, m_frac, m_mod, a1, a2, a3, c2d, c3d, c3dd, m_ratio, m_cnt;
  int s_int, s_frac, s_mod;
  bit m_err, m_pend;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_int = 32; m_frac = 0; m_mod = 2; a1 = 0; a2 = 0; a3 = 0;
      c2d = 0; c3d = 0; c3dd = 0; m_ratio = 32; m_cnt = 31;
      m_err = 0; m_pend = 0; s_int = 0; s_frac = 0; s_mod = 0;
    end else begin
      bit tk;
      tk = m_err ? m_pend : (m_cnt == 0);
      if (tk && m_pend) begin
        m_int = s_int; m_frac = s_frac; m_mod = s_mod;
        a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
        if (s_mod >= 2 && s_frac < s_mod && s_int >= 31 && s_int <= 511) begin
          m_err = 0; m_ratio = s_int; m_cnt = s_int - 1;
        end else m_err = 1;
        m_pend = 0;
      end else if (tk) begin
        int t1, t2, t3, k1, k2, k3, off, cand;
        t1 = a1 + m_frac; k1 = t1 / m_mod; t1 = t1 % m_mod;
        t2 = a2 + t1;     k2 = t2 / m_mod; t2 = t2 % m_mod;
        t3 = a3 + t2;     k3 = t3 / m_mod; t3 = t3 % m_mod;
        off  = k1 + k2 - c2d + k3 - 2 * c3d + c3dd;
        cand = m_int + off;
        if (cand >= 31 && cand <= 511) begin
          a1 = t1; a2 = t2; a3 = t3;
          c3dd = c3d; c3d = k3; c2d = k2;
          m_ratio = cand; m_cnt = cand - 1;
        end else m_err = 1;
      end else if (!m_err) m_cnt--;
      if (load) begin
        s_int = int_in; s_frac = frac_in; s_mod = mod_in; m_pend = 1;
      end
    end
  end

  // per-clock comparison (R10) and pulse spacing (R2)
  int gap = 0;
  bit have_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(div_value == m_ratio, "R10 div_value", div_value, m_ratio);
      chk(div_pulse == (!m_err && m_cnt == 0), "R10 div_pulse", div_pulse, (!m_err && m_cnt == 0));
      chk(cfg_err == m_err, "R10 cfg_err", cfg_err, m_err);
      gap++;
      if (cfg_err) have_prev = 0;
      else if (div_pulse) begin
        if (have_prev) chk(gap == div_value, "R2 pulse spacing", gap, div_value);
        gap = 0;
        have_prev = 1;
      end
    end else begin
      have_prev = 0;
      gap = 0;
    end
  end

  task automatic do_load(input int i, input int f, input int m);
    @(negedge clk);
    load = 1'b1; int_in = 9'(i); frac_in = 12'(f); mod_in = 12'(m);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic run_avg(input int i, input int f, input int m, input int k);
    int prev, sum, v, expv;
    do_load(i, f, m);
    prev = div_value;
    chk(div_value == prev && !div_pulse, "R6 no change mid-cycle", div_value, prev);
    wait_pulse();
    wait_pulse();
    chk(div_value == i, "R6 first cycle exact INT", div_value, i);
    sum = 0;
    for (int n = 0; n < m * k; n++) begin
      wait_pulse();
      v = div_value;
      chk(v >= i - 3 && v <= i + 4, "R5 dither window", v, i);
      if (f == 0) chk(v == i, "R3 zero fraction", v, i);
      sum += v;
    end
    expv = k * (m * i + f);
    chk(sum - expv <= 3 && expv - sum <= 3, "R4 average ratio", sum, expv);
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(div_value == 32, "R1 reset div_value", div_value, 32);
    chk(cfg_err == 0, "R1 reset cfg_err", cfg_err, 0);
    chk(div_pulse == 0, "R1 reset div_pulse", div_pulse, 0);
    rst = 1'b0;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!div_pulse);
    chk(cnt == 31, "R1 first pulse delay", cnt, 31);

    run_avg(40, 0, 7, 2);
    run_avg(100, 5, 13, 3);
    run_avg(60, 37, 100, 1);

    do_load(50, 2000, 4095);
    repeat (40) wait_pulse();
    chk(cfg_err == 0, "R10 wide modulus runs", cfg_err, 0);

    // illegal settings
    do_load(50, 9, 9);
    wait_pulse();
    @(negedge clk);
    chk(cfg_err == 1, "R7 FRAC>=MOD flagged", cfg_err, 1);
    cnt = 0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (div_pulse) cnt++;
    end
    chk(cnt == 0, "R7 no pulse in error", cnt, 0);
    do_load(50, 0, 1);
    @(negedge clk);
    chk(cfg_err == 1, "R7 MOD<2 flagged", cfg_err, 1);
    do_load(20, 0, 5);
    @(negedge clk);
    chk(cfg_err == 1, "R7 INT low flagged", cfg_err, 1);

    do_load(45, 3, 8);
    @(negedge clk);
    chk(cfg_err == 0, "R9 recovery clears error", cfg_err, 0);
    chk(div_value == 45, "R9 recovery ratio", div_value, 45);
    repeat (10) wait_pulse();

    // dither falls below the counter range
    do_load(31, 1, 3);
    cnt = 0;
    while (!cfg_err && cnt < 3000) begin @(negedge clk); cnt++; end
    chk(cfg_err == 1, "R8 range error", cfg_err, 1);
    chk(div_value >= 31, "R8 last legal ratio kept", div_value, 31);

    do_load(77, 11, 20);
    @(negedge clk);
    chk(cfg_err == 0, "R9 second recovery", cfg_err, 0);
    repeat (30) wait_pulse();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule